// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block takes level-sensitive interrupt requests from three GPIO banks of 14, 24 and 32 pins, 70 sources in all, and places them on 41 interrupt-controller inputs. Thirty-eight of those inputs are exclusive lines, and each of them carries the request of exactly one pin. The remaining three are shared lines, one for each bank. A shared line goes high when any pin of its bank that has no exclusive line is requesting. This way every pin keeps a path to the interrupt controller.

Which pin owns each exclusive line depends on a 32-bit routing word. Boot firmware loads it through a one-cycle write strobe. Each routing bit chooses between two candidate pins for one exclusive line. Six exclusive lines have a fixed owner and take no routing bit. All 41 outputs come from flops, so each output follows its inputs one cycle later.

Top module: `gpio_irq_router`

## Requirements
- R1: While `rst` is high at a clock edge, the routing word is cleared to zero. After that edge all 41 bits of `irq_out` are 0.
- R2: For exclusive lines 0 to 13, `irq_out[i]` carries bank 0 pin i when routing bit i is 0. It carries bank 2 pin i when routing bit i is 1.
- R3: For exclusive lines 14 to 31, `irq_out[i]` carries bank 1 pin i−14 when routing bit i is 0. It carries bank 2 pin i when routing bit i is 1.
- R4: Lines 32 to 37 always carry bank 1 pins 18 to 23. These pins never drive the bank 1 shared line.
- R5: `irq_out[38]` is the OR of the bank 0 pins p whose routing bit p is 1.
- R6: `irq_out[39]` is the OR of the bank 1 pins p (p from 0 to 17) whose routing bit p+14 is 1.
- R7: `irq_out[40]` is the OR of the bank 2 pins p whose routing bit p is 0.
- R8: A single active pin raises exactly one bit of `irq_out`. No pin appears on an exclusive line and a shared line at the same time.
- R9: The routing word takes `cfg_wdata` at a clock edge where `cfg_we` is 1. When `cfg_we` is 0, `cfg_wdata` has no effect. Routing from a new word shows on `irq_out` one edge after it is loaded.
- R10: Each output follows its input pins with exactly one clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Routing word write strobe |
| cfg_wdata | input | 32 | Routing word write data |
| bank0_irq | input | 14 | Bank 0 pin interrupt levels |
| bank1_irq | input | 24 | Bank 1 pin interrupt levels |
| bank2_irq | input | 32 | Bank 2 pin interrupt levels |
| irq_out | output | 41 | Lines 0–37 exclusive, 38–40 shared lines of banks 0, 1, 2 |

## Verification
The assertions assume that the pin levels and the write strobe are synchronous to `clk` and hold steady through each edge. They also assume that the routing word changes only through the strobe. The bench drives every input just after a falling edge. It writes the routing word only while reset is low, and it samples outputs at the following falling edges. The bench tests the exclusivity rule one pin at a time, because the checks that compare a shared line against a single pin hold only when no other pin is active.

// File: rtl/gir_pkg.sv
package gir_pkg;
  // Shared output lines, one per bank, placed after the exclusive lines
  localparam int SHARED_LINES = 3;
  typedef enum logic [1:0] {
    BANK_LOW  = 2'd0,
    BANK_MID  = 2'd1,
    BANK_HIGH = 2'd2
  } bank_id_e;
endpackage

// File: rtl/gir_cfg_reg.sv
module gir_cfg_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  // R9: a strobed write loads the word
  p_cfg_load_r9: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
  // R9: without the strobe the word holds
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/gir_direct_sel.sv
module gir_direct_sel #(
  parameter int B0_PINS  = 14,
  parameter int B1_PINS  = 24,
  parameter int B2_PINS  = 32,
  parameter int CFG_W    = 32,
  parameter int N_DIRECT = 38
) (
  input  logic [CFG_W-1:0]    cfg,
  input  logic [B0_PINS-1:0]  b0,
  input  logic [B1_PINS-1:0]  b1,
  input  logic [B2_PINS-1:0]  b2,
  output logic [N_DIRECT-1:0] direct
);
  // Line i: low range picks bank0/bank2, middle range bank1/bank2,
  // top range is owned by bank1 with no selection bit.
  for (genvar i = 0; i < N_DIRECT; i++) begin : g_line
    if (i < B0_PINS) begin : g_low
      assign direct[i] = cfg[i] ? b2[i] : b0[i];
    end else if (i < CFG_W) begin : g_mid
      assign direct[i] = cfg[i] ? b2[i] : b1[i-B0_PINS];
    end else begin : g_fixed
      assign direct[i] = b1[i-B0_PINS];
    end
  end
endmodule

// File: rtl/gir_shared_or.sv
module gir_shared_or #(
  parameter int B0_PINS = 14,
  parameter int B1_MUX  = 18,
  parameter int B2_PINS = 32,
  parameter int CFG_W   = 32
) (
  input  logic [CFG_W-1:0]   cfg,
  input  logic [B0_PINS-1:0] b0,
  input  logic [B1_MUX-1:0]  b1_mux,
  input  logic [B2_PINS-1:0] b2,
  output logic [2:0]         shared
);
  // A set bit hands the line to bank2, so banks 0/1 collect set-bit pins
  // and bank2 collects clear-bit pins.
  always_comb begin
    shared[gir_pkg::BANK_LOW]  = |(b0 & cfg[B0_PINS-1:0]);
    shared[gir_pkg::BANK_MID]  = |(b1_mux & cfg[CFG_W-1:B0_PINS]);
    shared[gir_pkg::BANK_HIGH] = |(b2 & ~cfg);
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int B0_PINS = 14,
  parameter int B1_PINS = 24,
  parameter int B2_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [B2_PINS-1:0]  cfg_wdata,
  input  logic [B0_PINS-1:0]  bank0_irq,
  input  logic [B1_PINS-1:0]  bank1_irq,
  input  logic [B2_PINS-1:0]  bank2_irq,
  output logic [B0_PINS+B1_PINS+gir_pkg::SHARED_LINES-1:0] irq_out
);
  localparam int CFG_W    = B2_PINS;
  localparam int N_DIRECT = B0_PINS + B1_PINS;
  localparam int N_OUT    = N_DIRECT + gir_pkg::SHARED_LINES;
  localparam int B1_MUX   = CFG_W - B0_PINS;

  logic [CFG_W-1:0]    cfg_q;
  logic [N_DIRECT-1:0] direct_c;
  logic [2:0]          shared_c;

  gir_cfg_reg #(.WIDTH(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  gir_direct_sel #(
    .B0_PINS(B0_PINS), .B1_PINS(B1_PINS), .B2_PINS(B2_PINS),
    .CFG_W(CFG_W), .N_DIRECT(N_DIRECT)
  ) u_direct (
    .cfg(cfg_q), .b0(bank0_irq), .b1(bank1_irq), .b2(bank2_irq),
    .direct(direct_c)
  );

  gir_shared_or #(
    .B0_PINS(B0_PINS), .B1_MUX(B1_MUX), .B2_PINS(B2_PINS), .CFG_W(CFG_W)
  ) u_shared (
    .cfg(cfg_q), .b0(bank0_irq), .b1_mux(bank1_irq[B1_MUX-1:0]),
    .b2(bank2_irq), .shared(shared_c)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= {shared_c, direct_c};
  end

  // R1: reset clears every line
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (irq_out == '0));

  // R4 / R10: fixed lines track their bank1 pins one cycle later
  for (genvar k = CFG_W; k < N_DIRECT; k++) begin : g_fixed_chk
    p_fixed_line_r4: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (irq_out[k] == $past(bank1_irq[k-B0_PINS])));
  end

  // R2 / R8: a lone bank0 pin reaches its own line and not the shared line
  for (genvar p = 0; p < B0_PINS; p++) begin : g_b0_chk
    p_b0_direct_r2: assert property (@(posedge clk) disable iff (rst)
      (bank0_irq[p] && !cfg_q[p]) |=> irq_out[p]);
    p_b0_excl_r8: assert property (@(posedge clk) disable iff (rst)
      ((bank0_irq == ({{(B0_PINS-1){1'b0}}, 1'b1} << p)) && !cfg_q[p])
      |=> !irq_out[N_DIRECT]);
  end

  // R7 / R8: a lone directly routed bank2 pin never raises its shared line
  for (genvar p = 0; p < B2_PINS; p++) begin : g_b2_chk
    p_b2_excl_r8: assert property (@(posedge clk) disable iff (rst)
      ((bank2_irq == ({{(B2_PINS-1){1'b0}}, 1'b1} << p)) && cfg_q[p])
      |=> !irq_out[N_OUT-1]);
  end

  // R7: an idle bank2 leaves its shared line low
  p_b2_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (bank2_irq == '0) |=> !irq_out[N_OUT-1]);

  // R6: bank1 shared line only rises when some muxed bank1 pin was active
  p_b1_shared_src_r6: assert property (@(posedge clk) disable iff (rst)
    (bank1_irq[B1_MUX-1:0] == '0) |=> !irq_out[N_OUT-2]);
endmodule

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [13:0] b0 = '0;
  logic [23:0] b1 = '0;
  logic [31:0] b2 = '0;
  logic [40:0] irq_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] cfg_model = '0;

  always #4 clk = ~clk; // 125 MHz

  gpio_irq_router dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bank0_irq(b0), .bank1_irq(b1), .bank2_irq(b2), .irq_out(irq_out)
  );

  // Expected lines, written from R2..R7
  function automatic logic [40:0] model(input logic [31:0] c, input logic [13:0] x0,
                                        input logic [23:0] x1, input logic [31:0] x2);
    logic [40:0] e;
    e = '0;
    for (int i = 0; i < 14; i++) e[i] = c[i] ? x2[i] : x0[i];            // R2
    for (int i = 14; i < 32; i++) e[i] = c[i] ? x2[i] : x1[i-14];        // R3
    for (int i = 32; i < 38; i++) e[i] = x1[i-14];                       // R4
    for (int p = 0; p < 14; p++) if (c[p] && x0[p]) e[38] = 1'b1;        // R5
    for (int p = 0; p < 18; p++) if (c[p+14] && x1[p]) e[39] = 1'b1;     // R6
    for (int p = 0; p < 32; p++) if (!c[p] && x2[p]) e[40] = 1'b1;       // R7
    return e;
  endfunction

  task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    cfg_model = v;
  endtask

  task automatic drive_and_check(input string req, input logic [13:0] x0,
                                 input logic [23:0] x1, input logic [31:0] x2);
    @(negedge clk); b0 = x0; b1 = x1; b2 = x2;
    @(negedge clk);
    check(req, irq_out, model(cfg_model, x0, x1, x2));
  endtask

  task automatic t_reset;
    rst = 1'b1; b0 = '1; b1 = '1; b2 = '1;
    repeat (3) @(negedge clk);
    check("R1 outputs zero in reset", irq_out, '0);
    rst = 1'b0; cfg_model = '0;
    @(negedge clk);
    // zero word: banks 0/1 own every exclusive line, bank2 on shared line
    check("R1 zero routing word", irq_out, model(32'h0, '1, '1, '1));
    check("R7 bank2 shared after reset", {40'b0, irq_out[40]}, 41'd1);
  endtask

  task automatic t_default_routing;
    drive_and_check("R2 bank0 direct", 14'h2A5C, '0, '0);
    drive_and_check("R3 bank1 direct", '0, 24'h03_C3A5, '0);
    drive_and_check("R4 fixed lines", '0, 24'hFC_0000, '0);
    drive_and_check("R7 bank2 shared only", '0, '0, 32'h0001_0000);
  endtask

  task automatic t_all_bank2;
    write_cfg(32'hFFFF_FFFF);
    drive_and_check("R2 bank2 on low lines", '0, '0, 32'h0000_1235);
    drive_and_check("R3 bank2 on mid lines", '0, '0, 32'h8765_4000);
    drive_and_check("R5 bank0 shared", 14'h0100, '0, '0);
    drive_and_check("R6 bank1 shared", '0, 24'h00_0400, '0);
    drive_and_check("R4 upper bank1 not shared", '0, 24'h80_0000, '0);
  endtask

  task automatic t_mixed;
    write_cfg(32'hA5C3_3C5A);
    drive_and_check("R2 R3 mixed all ones", '1, '1, '1);
    drive_and_check("R5 R6 R7 mixed pattern", 14'h1555, 24'h5A_A5A5, 32'hF00F_0FF0);
    drive_and_check("R7 bank2 clear-bit pin", '0, '0, 32'h0000_0001);
  endtask

  task automatic t_exclusive;
    logic [40:0] e;
    write_cfg(32'h6C39_D2B4);
    for (int n = 0; n < 70; n++) begin
      @(negedge clk);
      b0 = '0; b1 = '0; b2 = '0;
      if (n < 14) b0[n] = 1'b1;
      else if (n < 38) b1[n-14] = 1'b1;
      else b2[n-38] = 1'b1;
      @(negedge clk);
      e = model(cfg_model, b0, b1, b2);
      check("R8 single pin one line", {35'b0, 6'($countones(irq_out))}, 41'd1);
      check("R8 single pin routing", irq_out, e);
    end
  endtask

  task automatic t_write_ignored;
    write_cfg(32'h0);
    @(negedge clk); cfg_wdata = '1; b2 = '1; b0 = '0; b1 = '0;
    repeat (3) @(negedge clk);
    check("R9 wdata ignored without strobe", irq_out, model(32'h0, '0, '0, '1));
    cfg_wdata = '0;
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0000_0003;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    // word loaded at the edge just passed; outputs still show old routing
    check("R9 old routing until next edge", irq_out, model(32'h0, '0, '0, '1));
    @(negedge clk);
    cfg_model = 32'h0000_0003;
    check("R9 new routing one edge later", irq_out, model(32'h3, '0, '0, '1));
  endtask

  task automatic t_latency;
    write_cfg(32'h0);
    @(negedge clk); b0 = '0; b1 = '0; b2 = '0;
    @(negedge clk); b0 = 14'h3FFF;
    #1 check("R10 no change before edge", irq_out, '0);
    @(negedge clk);
    check("R10 change after one edge", irq_out, model(32'h0, 14'h3FFF, '0, '0));
    b0 = '0;
    @(negedge clk);
    check("R10 release after one edge", irq_out, '0);
  endtask

  initial begin
    t_reset();
    t_default_routing();
    t_all_bank2();
    t_mixed();
    t_exclusive();
    t_write_ignored();
    t_latency();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule